// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block sits on a two-wire clock/data serial bus as a slave and lets a bus master read and write a bank of 32 byte-wide control registers. It never drives the clock line. It pulls the data line low through an output-enable and never drives it high, so the pad and its pull-up form an open-drain line. Both bus lines are brought into the system clock domain through a two-flop synchronizer. The system clock must run at least eight times faster than the bus clock.

The device address is fixed at 7'b0111110. A transaction moves exactly one byte. A write carries a register-pointer byte and then one data byte. A read either sets the pointer first and then issues a repeated start, or skips the pointer phase and reuses the pointer latched by an earlier transaction. The pointer never advances by itself. A design-time mask marks each register as read/write or read-only. Read/write registers appear on a flat parallel output bus, and read-only registers are taken from a flat parallel input bus.

The block carries no data stream, so every pin is a plain level signal with no valid/ready handshake. The bus itself provides the only flow control: the master paces every bit with its clock.

Top module: `twowire_reg_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a start condition, and any start, including a repeated start in the middle of a transaction, begins a new address phase. A rise of SDA while SCL is high is a stop condition, which returns the block to idle.
- R2: When the address byte (shifted MSB first, bits 7:1 the device address, bit 0 the R/W flag with 1 meaning read) carries 7'b0111110, the slave pulls SDA low for the ninth clock, for both R/W values.
- R3: Any other address is not acknowledged. SDA stays released and all later bytes are ignored, with no register change, until the next start or stop.
- R4: A write (address with R/W=0, pointer byte, data byte, each acknowledged) loads the data byte into the addressed read/write register, which appears on `rw_regs_o[8*i +: 8]`. Every read/write register resets to 0x00.
- R5: With the default mask, registers 0x10 to 0x1F are read-only. A read of one returns `ro_regs_i[8*i +: 8]`. A write to one is acknowledged but changes nothing, and its slot of `rw_regs_o` stays 0x00.
- R6: After an acknowledged read address, the slave shifts out the register at the pointer, MSB first. It accepts either ACK or NACK from the master and then keeps SDA released for any further clocks, so those clocks read back 0xFF.
- R7: A read with no pointer phase returns the register at the most recently latched pointer, and repeated reads never advance the pointer.
- R8: A pointer of 0x20 or above is acknowledged. A read through it returns 0x00, and a write through it changes no register.
- R9: Only the first data byte of a write is taken. Further bytes before the stop are not acknowledged and are discarded.
- R10: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ro_regs_i | input | 256 | Read-only register values, byte i at bits 8*i+7:8*i |
| rw_regs_o | output | 256 | Read/write register values, byte i at bits 8*i+7:8*i |

## Verification
Every bus event reaches the protocol logic three system clocks after it appears at the pads: two synchronizer flops and one edge-detect flop. The slave's SDA response is registered one clock after that. An ACK or data bit is therefore on the line about four clocks after an SCL fall, and a register write lands about four clocks after the eighth SCL rise of the data byte. The bench holds each SCL phase for eight clocks, so the slave's drive has settled before the next edge. It samples SDA four clocks into the SCL high phase, and it reads the parallel outputs only after the stop, when every update is long complete. A port monitor flags any change of the output-enable while the master holds SCL high.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tw_state_e;

  typedef enum logic [1:0] {
    NX_REG,
    NX_WDATA,
    NX_RDATA,
    NX_DONE
  } tw_next_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_proto.sv
module tw_proto
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tw_state_e         state;
  tw_next_e          after_ack;
  logic              ack_slot;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] byte_in;
  logic              last_bit;

  assign byte_in  = {rx_sh[BYTE_W-2:0], sda_s};
  assign last_bit = (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= NX_DONE;
      ack_slot  <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ack_slot <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
        ack_slot <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              ack_slot <= 1'b0;
              if (byte_in[BYTE_W-1:1] == DEV_ADDR) begin
                state     <= ST_ACK;
                after_ack <= byte_in[0] ? NX_RDATA : NX_REG;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_REG: if (scl_rise) begin
            rx_sh   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              ptr_o     <= byte_in;
              state     <= ST_ACK;
              after_ack <= NX_WDATA;
              ack_slot  <= 1'b0;
            end
          end
          ST_WDATA: if (scl_rise) begin
            rx_sh   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= byte_in;
              state     <= ST_ACK;
              after_ack <= NX_DONE;
              ack_slot  <= 1'b0;
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_slot) begin
              sda_oe_o <= 1'b1;
              ack_slot <= 1'b1;
            end else begin
              ack_slot <= 1'b0;
              bit_cnt  <= '0;
              unique case (after_ack)
                NX_REG: begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_REG;
                end
                NX_WDATA: begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WDATA;
                end
                NX_RDATA: begin
                  tx_sh    <= rd_data_i;
                  sda_oe_o <= ~rd_data_i[BYTE_W-1];
                  state    <= ST_RDATA;
                end
                default: begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_IGNORE;
                end
              endcase
            end
          end
          ST_RDATA: if (scl_fall) begin
            if (last_bit) begin
              sda_oe_o <= 1'b0;
              state    <= ST_RACK;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~tx_sh[BYTE_W-2];
            end
          end
          ST_RACK: if (scl_rise) begin
            // master ACK and NACK are treated alike: no further byte
            state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_start_to_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR));

  assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe_o);

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_o));
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
  import tw_pkg::*;
#(
  parameter int                  NUM_REGS = 32,
  parameter logic [NUM_REGS-1:0] RO_MASK  = 32'hFFFF_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic [BYTE_W-1:0]          rd_addr_i,
  input  logic [NUM_REGS*BYTE_W-1:0] ro_flat_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] rw_flat_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] rd_vec [NUM_REGS];
  logic              wr_hit, rd_hit;

  assign wr_hit = (32'(wr_addr_i) < NUM_REGS);
  assign rd_hit = (32'(rd_addr_i) < NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (RO_MASK[i]) begin : g_ro
      assign rd_vec[i] = ro_flat_i[i*BYTE_W +: BYTE_W];
      assign rw_flat_o[i*BYTE_W +: BYTE_W] = '0;
    end else begin : g_rw
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en_i && wr_addr_i == BYTE_W'(i)) q <= wr_data_i;
      end
      assign rd_vec[i] = q;
      assign rw_flat_o[i*BYTE_W +: BYTE_W] = q;

      assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == BYTE_W'(i)) |=> (q == $past(wr_data_i)));
    end
  end

  assign rd_data_o = rd_hit ? rd_vec[rd_addr_i[IDX_W-1:0]] : '0;

  assert_ro_write_void_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_hit && RO_MASK[wr_addr_i[IDX_W-1:0]]) |=> $stable(rw_flat_o));

  assert_oor_write_void_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_hit) |=> $stable(rw_flat_o));

  assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data_o == '0));
endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import tw_pkg::*;
#(
  parameter int                  NUM_REGS    = 32,
  parameter logic [6:0]          DEV_ADDR    = 7'b0111110,
  parameter logic [NUM_REGS-1:0] RO_MASK     = 32'hFFFF_0000,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic [NUM_REGS*BYTE_W-1:0] ro_regs_i,
  output logic [NUM_REGS*BYTE_W-1:0] rw_regs_o
);
  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;
  logic              wr_en;

  tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  tw_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  tw_regbank #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (ptr),
    .wr_data_i (wr_data),
    .rd_addr_i (ptr),
    .ro_flat_i (ro_regs_i),
    .rd_data_o (rd_data),
    .rw_flat_o (rw_regs_o)
  );
endmodule

// File: tb/twowire_reg_slave_test.sv
module twowire_reg_slave_test;
  localparam int         NREG = 32;
  localparam logic [6:0] DEV  = 7'b0111110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] ro_in;
  logic [NREG*8-1:0] rw_out;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  bit done = 0;
  logic [7:0] mdl [NREG];

  always #10 clk = ~clk;

  assign sda_bus = ~(m_low | sda_oe);

  twowire_reg_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .ro_regs_i (ro_in),
    .rw_regs_o (rw_out)
  );

  // R10 port monitor: the enable must not move while the master holds SCL high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && m_scl) oe_viol++;
    oe_prev <= sda_oe;
  end

  function automatic bit is_ro(input int a);
    return a >= 16;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a >= NREG) return 8'h00;
    if (is_ro(a)) return ro_in[a*8 +: 8];
    return mdl[a];
  endfunction

  function automatic logic [NREG*8-1:0] exp_vec();
    logic [NREG*8-1:0] v = '0;
    for (int i = 0; i < NREG; i++) if (!is_ro(i)) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req);
    checks++;
    if (rw_out !== exp_vec()) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, rw_out, exp_vec());
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(4);
    m_scl = 1'b1; tick(8);
    m_low = 1'b1; tick(8);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(4);
    m_scl = 1'b1; tick(8);
    m_low = 1'b0; tick(8);
  endtask

  task automatic xfer_bit(input logic b, output logic s);
    m_low = ~b; tick(4);
    m_scl = 1'b1; tick(4);
    s = sda_bus; tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
    xfer_bit(1'b1, nack);
  endtask

  task automatic read_byte(input logic m_nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, s);
      v[i] = s;
    end
    xfer_bit(m_nack, s);
  endtask

  task automatic do_write(input int a, input logic [7:0] d, output logic [2:0] nk);
    bus_start();
    send_byte({DEV, 1'b0}, nk[2]);
    send_byte(8'(a), nk[1]);
    send_byte(d, nk[0]);
    bus_stop();
    if (a < NREG && !is_ro(a)) mdl[a] = d;
  endtask

  task automatic do_read(input int a, input logic m_nack, output logic [7:0] v,
                         output logic [2:0] nk);
    bus_start();
    send_byte({DEV, 1'b0}, nk[2]);
    send_byte(8'(a), nk[1]);
    bus_start();
    send_byte({DEV, 1'b1}, nk[0]);
    read_byte(m_nack, v);
    bus_stop();
  endtask

  task automatic do_short(output logic [7:0] v, output logic nk);
    bus_start();
    send_byte({DEV, 1'b1}, nk);
    read_byte(1'b1, v);
    bus_stop();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] nk;
    logic       n1, n2;
    logic [7:0] v;
    int         ptr_m;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    for (int i = 0; i < NREG; i++) ro_in[i*8 +: 8] = 8'($urandom);
    tick(5);
    chk("R10 reset enable", 32'(sda_oe), 0);
    chk_vec("R4 reset values");
    rst_n = 1'b1;
    tick(5);

    // R2 R4: write to a read/write register
    do_write(3, 8'hA5, nk);
    chk("R2 write acks", 32'(nk), 0);
    chk_vec("R4 write lands");
    do_write(4, 8'h3C, nk);
    chk_vec("R4 second write");

    // R6: full read, master NACK
    do_read(3, 1'b1, v, nk);
    chk("R2 read acks", 32'(nk), 0);
    chk("R6 full read data", 32'(v), 32'hA5);

    // R7: short reads reuse pointer 3 and do not advance
    do_short(v, n1);
    chk("R7 short read ack", 32'(n1), 0);
    chk("R7 short read data", 32'(v), 32'hA5);
    do_short(v, n1);
    chk("R7 no pointer advance", 32'(v), 32'hA5);

    // R5: read-only register
    do_write(8'h12, 8'hFF, nk);
    chk("R5 ro write acked", 32'(nk), 0);
    chk_vec("R5 ro write void");
    do_read(8'h12, 1'b1, v, nk);
    chk("R5 ro read input", 32'(v), 32'(ro_in[8'h12*8 +: 8]));

    // R3: wrong device address
    bus_start();
    send_byte({7'b0111111, 1'b0}, n1);
    send_byte(8'h02, n2);
    send_byte(8'h99, nk[0]);
    bus_stop();
    chk("R3 nack address", 32'(n1), 1);
    chk("R3 later bytes nacked", 32'({n2, nk[0]}), 32'h3);
    chk_vec("R3 registers untouched");

    // R8: pointer out of range
    do_write(8'h25, 8'h77, nk);
    chk("R8 oor write acked", 32'(nk), 0);
    chk_vec("R8 oor write void");
    do_read(8'h25, 1'b1, v, nk);
    chk("R8 oor read zero", 32'(v), 0);

    // R9: second data byte in one write
    bus_start();
    send_byte({DEV, 1'b0}, nk[2]);
    send_byte(8'h05, nk[1]);
    send_byte(8'h11, nk[0]);
    send_byte(8'h22, n1);
    bus_stop();
    mdl[5] = 8'h11;
    chk("R9 first byte acked", 32'(nk), 0);
    chk("R9 extra byte nacked", 32'(n1), 1);
    chk_vec("R9 only first byte");

    // R6: master ACK, then extra clocks read released line
    bus_start();
    send_byte({DEV, 1'b0}, nk[2]);
    send_byte(8'h04, nk[1]);
    bus_start();
    send_byte({DEV, 1'b1}, nk[0]);
    read_byte(1'b0, v);
    chk("R6 read after ack", 32'(v), 32'h3C);
    read_byte(1'b1, v);
    bus_stop();
    chk("R6 no second byte", 32'(v), 32'hFF);

    // R1: repeated start abandons a write after its pointer byte
    bus_start();
    send_byte({DEV, 1'b0}, nk[2]);
    send_byte(8'h07, nk[1]);
    bus_start();
    send_byte({DEV, 1'b0}, nk[0]);
    send_byte(8'h08, n1);
    send_byte(8'h5A, n2);
    bus_stop();
    mdl[8] = 8'h5A;
    chk("R1 restart acks", 32'({nk, n1, n2}), 0);
    chk_vec("R1 restart retargets");

    // random mix against the model
    ptr_m = 8;
    for (int it = 0; it < 50; it++) begin
      int op, a;
      logic [7:0] d;
      op = int'($urandom % 3);
      a  = int'($urandom % 40);
      d  = 8'($urandom);
      if (it == 25) for (int i = 0; i < NREG; i++) ro_in[i*8 +: 8] = 8'($urandom);
      if (op == 0) begin
        do_write(a, d, nk);
        ptr_m = a;
        chk("R4 random write acks", 32'(nk), 0);
        chk_vec("R4 random write state");
      end else if (op == 1) begin
        do_read(a, 1'(($urandom) & 1), v, nk);
        ptr_m = a;
        chk("R6 random full read", 32'(v), 32'(exp_rd(a)));
      end else begin
        do_short(v, n1);
        chk("R7 random short read", 32'(v), 32'(exp_rd(ptr_m)));
      end
    end

    chk("R10 enable moved only with SCL low", 32'(oe_viol), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule